// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width modulated outputs from one clock. Each channel has its own 6-bit clock prescaler, a 16-bit period count and a 16-bit duty count. It also has an enable, a polarity select and a drive-type select. Software programs the channel through a small 32-bit register port. One register holds all the enable, polarity and drive-type bits. One register holds all four prescale fields. Each channel also has its own period register and its own duty register.

A channel starts when its enable bit is set. At that moment it takes a copy of its prescale, period and duty values and begins at the start of its active phase. It keeps that copy until it is stopped and started again. When a channel is stopped, a settle window follows. The channel cannot start again until that window has ended. An enable that arrives during the window is held and takes effect exactly when the window ends.

Top module: `quad_pwm`

## Requirements
- R1: After reset, every register reads 0. All four outputs are high, which is the idle level for polarity bit 0. `drive_type` is 0.
- R2: Register map (byte offsets, `reg_addr[1:0]` must be 0):
  - Control at 0x00: enable of channel c in bit c, polarity in bit 8+c, drive type in bit 15+c.
  - Period of channel c at 0x04+8c and duty of channel c at 0x08+8c, each in bits 15:0.
  - Prescale at 0x24: the 6-bit field of channel c occupies bits (3-c)*6+5 down to (3-c)*6.
  - A read strobe returns the register on `reg_rdata` in the next cycle. Bits not listed read 0.
- R3: A write to any other offset, including a misaligned address, changes no register. A read of such an offset returns 0.
- R4: An enabled channel with prescale P, period N and duty D repeats every (P+1)*N cycles. It is active for the first (P+1)*D cycles of each repeat. The first active cycle is the cycle after the clock edge that writes the enable.
- R5: Polarity bit 1 drives the active phase high and the inactive phase low. Polarity bit 0 inverts the output.
- R6: A channel whose enable bit is 0 drives its inactive level. This holds from the cycle after the clock edge at which the bit is cleared.
- R7: A duty count of 0 gives a constant inactive output. A duty count greater than or equal to the period count gives a constant active output.
- R8: A period count of 0 or 1 behaves as a period count of 2.
- R9: Prescale, period and duty are captured when the channel starts. Writes to them while the channel runs do not change the waveform until the channel is restarted.
- R10: After a running channel is stopped, it stays inactive for GAP_CYCLES cycles. An enable set in that window starts the channel, at the beginning of its active phase, on the edge after the window ends. With an enable written two edges after the disable, the first active cycle comes GAP_CYCLES cycles after that enable write. After the window, the channel restarts normally.
- R11: `drive_type[c]` follows control bit 15+c. The value 0 selects push-pull drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port and the counters |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| pwm_out | output | 4 | Waveform outputs, one bit per channel |
| drive_type | output | 4 | Drive-type select per channel, 0 = push-pull |

## Verification
The hardest case to reach is an enable that lands inside the settle window. It needs a running channel, then a disable write, then an enable write two edges later. The enable has to arrive while the window counter is still busy. The bench issues these two writes back to back. It then checks every cycle that the output stays at its idle level, and that the first active cycle comes exactly GAP_CYCLES cycles after the enable write. The capture rule is tested a similar way: new period, duty and prescale values are written while a channel runs. The expected waveform keeps its cycle index running across those writes.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;

    localparam int NCH     = 4;
    localparam int CNT_W   = 16;
    localparam int PRE_W   = 6;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;

    // Bit bases inside the shared control word.
    localparam int EN_BASE   = 0;
    localparam int POL_BASE  = 8;
    localparam int TYPE_BASE = 15;

    localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(6'h00);
    localparam logic [ADDR_W-1:0] OFS_PRE = ADDR_W'(6'h24);

    localparam logic [CNT_W-1:0] MIN_PERIOD = CNT_W'(2);

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [PRE_W-1:0] pre_t;

    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] pol;
        logic [NCH-1:0] dtype;
    } ctl_t;

    // Prescale fields are packed with channel 0 in the highest field.
    function automatic int pre_lsb(input int ch);
        return (NCH - 1 - ch) * PRE_W;
    endfunction

    function automatic logic [ADDR_W-1:0] period_ofs(input int ch);
        return ADDR_W'(4 + 8 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] duty_ofs(input int ch);
        return ADDR_W'(8 + 8 * ch);
    endfunction

endpackage

// File: rtl/quad_pwm_regs.sv
module quad_pwm_regs
    import quad_pwm_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic                         rd,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output ctl_t                         ctl,
    output logic [NCH-1:0][CNT_W-1:0]    period,
    output logic [NCH-1:0][CNT_W-1:0]    duty,
    output logic [NCH-1:0][PRE_W-1:0]    pre
);

    typedef struct packed {
        ctl_t                      ctl;
        logic [NCH-1:0][CNT_W-1:0] per;
        logic [NCH-1:0][CNT_W-1:0] dty;
        logic [NCH-1:0][PRE_W-1:0] pre;
        logic [DATA_W-1:0]         rdata;
    } regs_t;

    regs_t s_d, s_q;

    logic              aligned;
    logic              hit_ctl;
    logic              hit_pre;
    logic [NCH-1:0]    hit_per;
    logic [NCH-1:0]    hit_dty;
    logic [DATA_W-1:0] rd_val;

    // Address decode
    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        hit_ctl = aligned && (addr == OFS_CTL);
        hit_pre = aligned && (addr == OFS_PRE);
        for (int ch = 0; ch < NCH; ch++) begin
            hit_per[ch] = aligned && (addr == period_ofs(ch));
            hit_dty[ch] = aligned && (addr == duty_ofs(ch));
        end
    end

    // Read mux and next-state
    always_comb begin
        s_d    = s_q;
        rd_val = '0;

        if (hit_ctl) begin
            for (int ch = 0; ch < NCH; ch++) begin
                rd_val[EN_BASE + ch]   = s_q.ctl.en[ch];
                rd_val[POL_BASE + ch]  = s_q.ctl.pol[ch];
                rd_val[TYPE_BASE + ch] = s_q.ctl.dtype[ch];
            end
        end
        if (hit_pre) begin
            for (int ch = 0; ch < NCH; ch++) begin
                rd_val[pre_lsb(ch) +: PRE_W] = s_q.pre[ch];
            end
        end
        for (int ch = 0; ch < NCH; ch++) begin
            if (hit_per[ch]) rd_val[CNT_W-1:0] = s_q.per[ch];
            if (hit_dty[ch]) rd_val[CNT_W-1:0] = s_q.dty[ch];
        end

        if (wr) begin
            if (hit_ctl) begin
                for (int ch = 0; ch < NCH; ch++) begin
                    s_d.ctl.en[ch]    = wdata[EN_BASE + ch];
                    s_d.ctl.pol[ch]   = wdata[POL_BASE + ch];
                    s_d.ctl.dtype[ch] = wdata[TYPE_BASE + ch];
                end
            end
            if (hit_pre) begin
                for (int ch = 0; ch < NCH; ch++) begin
                    s_d.pre[ch] = wdata[pre_lsb(ch) +: PRE_W];
                end
            end
            for (int ch = 0; ch < NCH; ch++) begin
                if (hit_per[ch]) s_d.per[ch] = wdata[CNT_W-1:0];
                if (hit_dty[ch]) s_d.dty[ch] = wdata[CNT_W-1:0];
            end
        end

        if (rd) begin
            s_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata  = s_q.rdata;
    assign ctl    = s_q.ctl;
    assign period = s_q.per;
    assign duty   = s_q.dty;
    assign pre    = s_q.pre;

endmodule

// File: rtl/quad_pwm_chan.sv
module quad_pwm_chan
    import quad_pwm_pkg::*;
#(
    parameter int GAP_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  pre_t pre_cfg,
    input  cnt_t per_cfg,
    input  cnt_t duty_cfg,
    output logic run,
    output logic active,
    output logic busy
);

    localparam int GAP_W = $clog2(GAP_CYCLES + 2);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYCLES);

    typedef struct packed {
        logic             run;
        logic [GAP_W-1:0] gap;
        pre_t             pre_cnt;
        pre_t             pre_cap;
        cnt_t             per_cnt;
        cnt_t             per_lim;
        cnt_t             duty_cap;
    } chan_t;

    chan_t c_d, c_q;
    cnt_t  per_eff;

    always_comb begin
        c_d     = c_q;
        per_eff = (per_cfg < MIN_PERIOD) ? MIN_PERIOD : per_cfg;

        if (c_q.gap != '0) begin
            c_d.gap = c_q.gap - 1'b1;
        end

        if (c_q.run) begin
            if (!en) begin
                // Stop and open the settle window.
                c_d.run = 1'b0;
                c_d.gap = GAP_LOAD;
            end else if (c_q.pre_cnt == c_q.pre_cap) begin
                c_d.pre_cnt = '0;
                if (c_q.per_cnt == c_q.per_lim - 1'b1) begin
                    c_d.per_cnt = '0;
                end else begin
                    c_d.per_cnt = c_q.per_cnt + 1'b1;
                end
            end else begin
                c_d.pre_cnt = c_q.pre_cnt + 1'b1;
            end
        end else if (en && (c_q.gap == '0)) begin
            // Start: capture settings and begin at the active phase.
            c_d.run      = 1'b1;
            c_d.pre_cnt  = '0;
            c_d.per_cnt  = '0;
            c_d.pre_cap  = pre_cfg;
            c_d.per_lim  = per_eff;
            c_d.duty_cap = duty_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign run    = c_q.run;
    assign active = c_q.run && (c_q.per_cnt < c_q.duty_cap);
    assign busy   = (c_q.gap != '0);

endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
    import quad_pwm_pkg::*;
#(
    parameter int GAP_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH-1:0]    drive_type
);

    ctl_t                      ctl;
    logic [NCH-1:0][CNT_W-1:0] period_cfg;
    logic [NCH-1:0][CNT_W-1:0] duty_cfg;
    logic [NCH-1:0][PRE_W-1:0] pre_cfg;
    logic [NCH-1:0]            ch_run;
    logic [NCH-1:0]            ch_active;
    logic [NCH-1:0]            ch_busy;

    quad_pwm_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .ctl    (ctl),
        .period (period_cfg),
        .duty   (duty_cfg),
        .pre    (pre_cfg)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        quad_pwm_chan #(
            .GAP_CYCLES (GAP_CYCLES)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ctl.en[g]),
            .pre_cfg  (pre_cfg[g]),
            .per_cfg  (period_cfg[g]),
            .duty_cfg (duty_cfg[g]),
            .run      (ch_run[g]),
            .active   (ch_active[g]),
            .busy     (ch_busy[g])
        );

        // Polarity 1: active high; polarity 0: inverted.
        assign pwm_out[g] = ch_active[g] ~^ ctl.pol[g];
    end

    assign drive_type = ctl.dtype;

endmodule

// File: rtl/quad_pwm_chk.sv
module quad_pwm_chk
    import quad_pwm_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            en,
    input logic [NCH-1:0]            pol,
    input logic [NCH-1:0]            run,
    input logic [NCH-1:0]            active,
    input logic [NCH-1:0]            busy,
    input logic [NCH-1:0][CNT_W-1:0] duty,
    input logic [NCH-1:0]            pwm_out
);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            !en[g] |=> (pwm_out[g] == !pol[g])); // R6

        AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            run[g] |-> $past(en[g])); // R6

        AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            busy[g] |-> (!run[g] && !active[g])); // R10

        AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(run[g]) && ($past(duty[g]) != '0)) |-> active[g]); // R4
    end

endmodule

bind quad_pwm quad_pwm_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctl.en),
    .pol     (ctl.pol),
    .run     (ch_run),
    .active  (ch_active),
    .busy    (ch_busy),
    .duty    (duty_cfg),
    .pwm_out (pwm_out)
);

// File: tb/quad_pwm_bench.sv
module quad_pwm_bench;

    localparam int GAP = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  pwm_out;
    logic [3:0]  drive_type;

    int checks = 0;
    int errors = 0;
    logic [31:0] ctl_sh = '0;
    logic [31:0] pre_sh = '0;

    always #10 clk = ~clk;

    quad_pwm #(.GAP_CYCLES(GAP)) u_quad_pwm (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pwm_out    (pwm_out),
        .drive_type (drive_type)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic exp_out(input int k, input int pre, input int per,
                                     input int duty, input logic pol);
        int peff = (per < 2) ? 2 : per;
        int idx = (k / (pre + 1)) % peff;
        return (idx < duty) ? pol : !pol;
    endfunction

    task automatic set_ctl(input int ch, input logic en, input logic pol);
        ctl_sh[ch] = en;
        ctl_sh[8 + ch] = pol;
        wr_reg(6'h00, ctl_sh);
    endtask

    task automatic program_ch(input int ch, input int pre, input int per, input int duty);
        pre_sh[(3 - ch) * 6 +: 6] = 6'(pre);
        wr_reg(6'h24, pre_sh);
        wr_reg(6'(4 + 8 * ch), 32'(per));
        wr_reg(6'(8 + 8 * ch), 32'(duty));
    endtask

    task automatic stop_ch(input int ch, input logic pol, input string tag);
        set_ctl(ch, 1'b0, pol);
        @(posedge clk); @(negedge clk);
        chk({tag, " idle level after disable"}, 32'(pwm_out[ch]), 32'(!pol));
        repeat (GAP + 4) @(negedge clk);
    endtask

    task automatic run_wave(input int ch, input int pre, input int per, input int duty,
                            input logic pol, input int ncyc, input string tag);
        program_ch(ch, pre, per, duty);
        set_ctl(ch, 1'b1, pol);
        for (int k = 0; k < ncyc; k++) begin
            @(posedge clk); @(negedge clk);
            chk(tag, 32'(pwm_out[ch]), 32'(exp_out(k, pre, per, duty, pol)));
        end
        stop_ch(ch, pol, tag);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 outputs idle high", 32'(pwm_out), 32'h0000000F);
        chk("R1 drive_type", 32'(drive_type), 32'h0);
        rd_reg(6'h00, d); chk("R1 ctl", d, 32'h0);
        rd_reg(6'h24, d); chk("R1 prescale", d, 32'h0);
        rd_reg(6'h0C, d); chk("R1 period ch1", d, 32'h0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        wr_reg(6'h14, 32'h1234ABCD);
        rd_reg(6'h14, d); chk("R2 period ch2 readback", d, 32'h0000ABCD);
        wr_reg(6'h20, 32'hFFFF0001);
        rd_reg(6'h20, d); chk("R2 duty ch3 readback", d, 32'h00000001);
        wr_reg(6'h00, 32'hFFFFFFF0);
        rd_reg(6'h00, d); chk("R2 ctl masked", d, 32'h00078F00);
        chk("R11 drive_type all", 32'(drive_type), 32'hF);
        wr_reg(6'h24, 32'hFFFFFFFF);
        rd_reg(6'h24, d); chk("R2 prescale masked", d, 32'h00FFFFFF);
        wr_reg(6'h24, 32'h00040000);
        rd_reg(6'h24, d); chk("R2 prescale ch0 field", d, 32'h00040000);
        wr_reg(6'h28, 32'hFFFFFFFF);
        wr_reg(6'h02, 32'hFFFFFFFF);
        wr_reg(6'h15, 32'h00000000);
        rd_reg(6'h28, d); chk("R3 undefined reads 0", d, 32'h0);
        rd_reg(6'h00, d); chk("R3 ctl untouched", d, 32'h00078F00);
        rd_reg(6'h14, d); chk("R3 period ch2 untouched", d, 32'h0000ABCD);
        wr_reg(6'h00, 32'h00008000);
        chk("R11 drive_type ch0", 32'(drive_type), 32'h1);
        wr_reg(6'h00, 32'h0);
        wr_reg(6'h24, 32'h0);
        ctl_sh = '0; pre_sh = '0;
    endtask

    task automatic t_capture;
        int pre = 0, per = 6, duty = 3;
        program_ch(0, pre, per, duty);
        set_ctl(0, 1'b1, 1'b1);
        @(posedge clk); @(negedge clk);
        chk("R9 capture k0", 32'(pwm_out[0]), 32'(exp_out(0, pre, per, duty, 1'b1)));
        pre_sh[18 +: 6] = 6'd3;
        wr_reg(6'h24, pre_sh);
        wr_reg(6'h04, 32'd2);
        wr_reg(6'h08, 32'd1);
        chk("R9 capture k6", 32'(pwm_out[0]), 32'(exp_out(6, pre, per, duty, 1'b1)));
        for (int k = 7; k < 30; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R9 old settings kept", 32'(pwm_out[0]), 32'(exp_out(k, pre, per, duty, 1'b1)));
        end
        stop_ch(0, 1'b1, "R9");
        set_ctl(0, 1'b1, 1'b1);
        for (int k = 0; k < 24; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R9 new settings after restart", 32'(pwm_out[0]), 32'(exp_out(k, 3, 2, 1, 1'b1)));
        end
        stop_ch(0, 1'b1, "R9");
    endtask

    task automatic t_gap;
        program_ch(1, 0, 4, 2);
        set_ctl(1, 1'b1, 1'b1);
        repeat (5) @(negedge clk);
        set_ctl(1, 1'b0, 1'b1);
        set_ctl(1, 1'b1, 1'b1);
        for (int i = 1; i < GAP; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R10 held inactive in window", 32'(pwm_out[1]), 32'h0);
        end
        for (int k = 0; k < 12; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R10 restart at active phase", 32'(pwm_out[1]), 32'(exp_out(k, 0, 4, 2, 1'b1)));
        end
        stop_ch(1, 1'b1, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        run_wave(0, 0, 5, 2, 1'b1, 20, "R4 R5 normal ch0");
        run_wave(1, 2, 4, 3, 1'b0, 30, "R4 R5 inverted ch1");
        run_wave(2, 0, 3, 0, 1'b1, 12, "R7 zero duty");
        run_wave(2, 1, 3, 7, 1'b1, 12, "R7 full duty");
        run_wave(3, 1, 1, 1, 1'b1, 16, "R8 short period");
        run_wave(3, 0, 0, 1, 1'b0, 8, "R8 zero period");
        t_capture();
        t_gap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule